// File: doc/BRIEF.md
# Cluster Flip-Address Sequencer

This block sits between a tester-side stimulus source and a grid of randomly addressable scan clusters. Each stimulus vector arrives fully resolved, with one bit for each cluster. A second input gives each cluster's reset polarity, which is the value the cluster holds straight after the grid's reset. A cluster only needs attention when its required value differs from that reset value. For each vector, the block walks the clusters and emits the address of every cluster that must toggle. Clusters that already match are never addressed. A dense vector of N bits is therefore reduced to a short list of addresses.

Each address word has an X field in the upper bits and a Y field in the lower bits. The address of cluster index i is the binary value of i, so cluster (x, y) has index x * 2^Y_BITS + y. Addresses leave one per cycle over a valid/ready handshake, lowest index first. A single-cycle `done` pulse closes each vector. A new vector is taken only once the previous one has finished. Unspecified stimulus bits are assumed to have been replaced by the cluster's reset value before they reach this block, so they never cause an access.

Top module: `cas_seq`

## Requirements
- R1: The address is AW = ceil(log2(N_CLUSTERS)) bits wide. `addr_word` = {`addr_x`, `addr_y`}, with the X field (AW-Y_BITS bits) in the upper bits and the Y field (Y_BITS bits) in the lower bits. For cluster index i, `addr_word` equals i.
- R2: For a vector, the set of emitted addresses is exactly the set of indices i where `vec_bits[i]` differs from `vec_pol[i]`.
- R3: Addresses are emitted in strictly ascending index order, and each flipping cluster is emitted exactly once.
- R4: While `addr_ready` stays high, addresses are handed over on consecutive cycles. If the vector is accepted at edge k and has n flips, `done` is high in the cycle after edge k+n+1.
- R5: The first address is valid in the cycle after the edge that follows acceptance, that is, one cycle of latency.
- R6: While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high and `addr_word` holds its value.
- R7: `done` is a one-cycle pulse. It is raised after the last address handshake and is never high together with `addr_valid`.
- R8: A vector with no flipping cluster produces `done` in the cycle after the edge that follows acceptance, and no address is emitted.
- R9: `vec_ready` is low from acceptance until `done`. `vec_valid` and `vec_bits` applied during that time have no effect on the emitted sequence.
- R10: While synchronous reset is applied and immediately after it, `vec_ready` is 1, `addr_valid` is 0 and `done` is 0. A reset in the middle of a vector abandons that vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_valid | input | 1 | A stimulus vector is offered |
| vec_ready | output | 1 | The block can take a vector |
| vec_bits | input | N_CLUSTERS | Required value for each cluster |
| vec_pol | input | N_CLUSTERS | Reset value for each cluster |
| addr_valid | output | 1 | `addr_word` holds a cluster to toggle |
| addr_ready | input | 1 | The consumer takes the address |
| addr_word | output | AW | Full cluster address {X, Y} |
| addr_x | output | AW-Y_BITS | X field of the address |
| addr_y | output | Y_BITS | Y field of the address |
| done | output | 1 | The current vector is finished (one-cycle pulse) |

## Verification
A stale bit left in the pending mask appears at the ports as an extra or repeated address before `done`. A bit that is lost appears as a missing address. Either fault is caught against the list the bench derives from `vec_bits ^ vec_pol` in the same vector. A wrong state transition shifts `done` or the first address away from its fixed cycle after acceptance, so it shows within one or two cycles. A broken hold under backpressure changes `addr_word` in the first stalled cycle.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EMIT = 2'd2
  } cas_state_e;

endpackage

// File: rtl/cas_low_pick.sv
module cas_low_pick #(
  parameter int N  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  mask,
  output logic [AW-1:0] idx,
  output logic          found
);

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        idx   = AW'(i);
        found = 1'b1;
      end
    end
  end

  // R3: the chosen index always names a pending cluster
  assert_pick_set_R3: assert property (@(posedge clk) disable iff (rst)
    found |-> mask[idx]);

  // R3: nothing is picked from an empty mask
  assert_pick_empty_R3: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |-> !found);

endmodule

// File: rtl/cas_pend_mask.sv
module cas_pend_mask #(
  parameter int N  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [N-1:0]  load_val,
  input  logic          clr,
  input  logic [AW-1:0] clr_idx,
  output logic [N-1:0]  mask,
  output logic          any
);

  logic [N-1:0] clr_onehot;

  always_comb begin
    clr_onehot = '0;
    clr_onehot[clr_idx] = clr;
  end

  always_ff @(posedge clk) begin
    if (rst)
      mask <= '0;
    else if (load)
      mask <= load_val;
    else
      mask <= mask & ~clr_onehot;
  end

  assign any = |mask;

  // R3: a cleared cluster stays cleared, so it is never emitted twice
  assert_clr_sticks_R3: assert property (@(posedge clk) disable iff (rst)
    (clr && !load) |=> !mask[$past(clr_idx)]);

  // R3: without a new load the mask only loses bits
  assert_mask_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> ((mask & ~$past(mask)) == '0));

endmodule

// File: rtl/cas_seq.sv
module cas_seq #(
  parameter int N_CLUSTERS = 16,
  parameter int Y_BITS     = 2,
  localparam int AW        = (N_CLUSTERS > 1) ? $clog2(N_CLUSTERS) : 1,
  localparam int XW        = (AW > Y_BITS) ? AW - Y_BITS : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  vec_valid,
  output logic                  vec_ready,
  input  logic [N_CLUSTERS-1:0] vec_bits,
  input  logic [N_CLUSTERS-1:0] vec_pol,
  output logic                  addr_valid,
  input  logic                  addr_ready,
  output logic [AW-1:0]         addr_word,
  output logic [XW-1:0]         addr_x,
  output logic [Y_BITS-1:0]     addr_y,
  output logic                  done
);
  import cas_pkg::*;

  cas_state_e            st;
  logic [N_CLUSTERS-1:0] pend;
  logic                  pend_any;
  logic [AW-1:0]         low_idx;
  logic                  low_found;
  logic                  load_en;
  logic                  take;
  logic                  consume;

  assign vec_ready = (st == ST_IDLE);
  assign load_en   = vec_valid && vec_ready;
  assign take      = (st == ST_LOAD) || ((st == ST_EMIT) && addr_ready);
  assign consume   = take && pend_any;

  cas_pend_mask #(.N(N_CLUSTERS), .AW(AW)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .load     (load_en),
    .load_val (vec_bits ^ vec_pol),
    .clr      (consume),
    .clr_idx  (low_idx),
    .mask     (pend),
    .any      (pend_any)
  );

  cas_low_pick #(.N(N_CLUSTERS), .AW(AW)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .mask  (pend),
    .idx   (low_idx),
    .found (low_found)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      addr_valid <= 1'b0;
      addr_word  <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (load_en) st <= ST_LOAD;
        end
        ST_LOAD, ST_EMIT: begin
          if (take) begin
            if (low_found) begin
              addr_word  <= low_idx;
              addr_valid <= 1'b1;
              st         <= ST_EMIT;
            end else begin
              addr_valid <= 1'b0;
              done       <= 1'b1;
              st         <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  generate
    if (AW > Y_BITS) begin : g_split
      assign addr_x = addr_word[AW-1:Y_BITS];
      assign addr_y = addr_word[Y_BITS-1:0];
    end else begin : g_y_only
      assign addr_x = '0;
      assign addr_y = Y_BITS'(addr_word);
    end
  endgenerate

  // R6: a stalled address is held
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_word)));

  // R7: done never overlaps a valid address
  assert_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(done && addr_valid));

  // R7: done lasts a single cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: no new vector while addresses are pending
  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> !vec_ready);

  // R3: successive addresses of a vector rise
  assert_ascend_R3: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && addr_ready) |=> (!addr_valid || (addr_word > $past(addr_word))));

  // R5: an accepted vector yields an address or done on the next edge
  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    load_en |=> ##1 (addr_valid || done));

endmodule

// File: tb/tb_cas_seq.sv
module tb_cas_seq;
  localparam int N  = 16;
  localparam int YB = 2;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vec_valid = 1'b0;
  logic          vec_ready;
  logic [N-1:0]  vec_bits = '0;
  logic [N-1:0]  vec_pol = '0;
  logic          addr_valid;
  logic          addr_ready = 1'b0;
  logic [AW-1:0] addr_word;
  logic [1:0]    addr_x;
  logic [1:0]    addr_y;
  logic          done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  cas_seq #(.N_CLUSTERS(N), .Y_BITS(YB)) dut (
    .clk(clk), .rst(rst), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_bits(vec_bits), .vec_pol(vec_pol), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr_word(addr_word), .addr_x(addr_x),
    .addr_y(addr_y), .done(done)
  );

  always #2 clk = ~clk;

  // columns: bits, pol, ready mode, junk vector during run
  localparam int NV = 6;
  localparam logic [N-1:0] TV_BITS [NV] = '{16'hA62D, 16'hFFFF, 16'h0000,
                                            16'h8001, 16'h5A5A, 16'h1234};
  localparam logic [N-1:0] TV_POL  [NV] = '{16'h0000, 16'hFFFF, 16'hFFFF,
                                            16'h0000, 16'h0F0F, 16'h1230};
  localparam int           TV_MODE [NV] = '{0, 0, 0, 1, 2, 1};
  localparam bit           TV_JUNK [NV] = '{0, 0, 0, 0, 1, 1};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit rdy_of(input int mode, input int it);
    case (mode)
      1:       return (it % 2) == 0;
      2:       return it > 3;
      default: return 1'b1;
    endcase
  endfunction

  task automatic run_vec(input logic [N-1:0] b, input logic [N-1:0] p,
                         input int mode, input bit junk);
    int exp_idx[N];
    int n;
    int got;
    int first_it;
    int done_it;
    bit prev_stall;
    logic [AW-1:0] prev_word;
    n = 0;
    for (int i = 0; i < N; i++)
      if (b[i] != p[i]) begin exp_idx[n] = i; n++; end
    got = 0; first_it = -1; done_it = -1; prev_stall = 0; prev_word = '0;
    @(negedge clk);
    while (!vec_ready) @(negedge clk);
    vec_bits = b; vec_pol = p; vec_valid = 1'b1;
    for (int it = 0; it < 200; it++) begin
      @(negedge clk);
      if (it == 0) begin
        if (junk) begin vec_bits = ~b; vec_pol = 16'h5555; end
        else vec_valid = 1'b0;
      end
      addr_ready = rdy_of(mode, it);
      #1;
      if (prev_stall)
        check(addr_valid && addr_word == prev_word, "R6 hold", int'(addr_word), int'(prev_word));
      check(!(done && addr_valid), "R7 exclusive", int'(done), 0);
      if (!done) check(!vec_ready, "R9 busy", int'(vec_ready), 0);
      if (addr_valid && first_it < 0) first_it = it;
      if (addr_valid && addr_ready) begin
        if (got < n) begin
          check(int'(addr_word) == exp_idx[got], "R2/R3 address", int'(addr_word), exp_idx[got]);
          check(addr_x == 2'(exp_idx[got] >> 2) && addr_y == 2'(exp_idx[got] & 3),
                "R1 fields", int'({addr_x, addr_y}), exp_idx[got]);
        end else check(1'b0, "R2 extra address", int'(addr_word), -1);
        got++;
      end
      prev_stall = addr_valid && !addr_ready;
      prev_word  = addr_word;
      if (done) begin
        done_it = it;
        vec_valid = 1'b0;
        break;
      end
    end
    check(got == n, "R2 count", got, n);
    if (mode == 0) check(done_it == n + 1, "R4 back-to-back", done_it, n + 1);
    if (n > 0) check(first_it == 1, "R5 first address latency", first_it, 1);
    else check(done_it == 1 && first_it < 0, "R8 empty vector", done_it, 1);
    @(negedge clk); #1;
    check(!done && !addr_valid, "R7 done pulse", int'(done), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(vec_ready && !addr_valid && !done, "R10 in reset", int'({vec_ready, addr_valid, done}), 4);
    rst = 1'b0;
    @(negedge clk); #1;
    check(vec_ready && !addr_valid && !done, "R10 after reset", int'({vec_ready, addr_valid, done}), 4);

    for (int v = 0; v < NV; v++)
      run_vec(TV_BITS[v], TV_POL[v], TV_MODE[v], TV_JUNK[v]);

    // R10: reset in the middle of a vector abandons it
    @(negedge clk);
    vec_bits = 16'hFF00; vec_pol = 16'h0000; vec_valid = 1'b1; addr_ready = 1'b0;
    @(negedge clk);
    vec_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #1;
    check(vec_ready && !addr_valid && !done, "R10 mid-run reset", int'({vec_ready, addr_valid, done}), 4);
    rst = 1'b0;
    run_vec(16'h0003, 16'h0000, 0, 0);
    // R1: the highest index maps to all-ones fields
    run_vec(16'h8000, 16'h0000, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule